// File: doc/BRIEF.md
# Dual-Bank Affine Color Matrix Converter

This block converts a stream of three-component pixels from one color space to another by applying a 3x4 affine matrix. Each of the three outputs is a weighted sum of the three input components plus a per-row offset. The sum is kept at full precision, rounded to the nearest output code and clamped to the unsigned output range. Pixels enter and leave on a valid-qualified stream with a fixed three-cycle latency.

The matrix comes from one of five sources, chosen by a mode field in a control register: a pass-through identity, two built-in RGB-to-YCbCr matrices (standard- and high-definition luma weights, full range), or one of two programmable coefficient banks. Software loads the bank that is not in use through a simple register write port and then switches to it with a single control write. The mode is sampled once per accepted pixel, so a switch never gives a pixel a mix of coefficients.

Input components are unsigned 12-bit codes with 8 integer and 4 fraction bits. Outputs are unsigned 8-bit integers.

Top module: `cmat_convert`

## Requirements
- R1: After reset, out_valid is 0, the mode field reads 0 (pass-through) and every bank register reads 0.
- R2: A pixel accepted with in_valid high at a clock edge appears with out_valid high exactly three rising edges later; out_valid is low in the two edges between, and back-to-back pixels come out back to back.
- R3: Row r of the active matrix holds C[4r], C[4r+1], C[4r+2] (signed, 13 fraction bits, 0x2000 = 1.0) and offset C[4r+3] (signed, 13 fraction bits, in units of the 256-code full scale, so 0x200 adds 16 codes). With x0..x2 the raw 12-bit input codes, output r is sat(round((C[4r]*x0 + C[4r+1]*x1 + C[4r+2]*x2 + C[4r+3]*4096) / 2^17)).
- R4: Rounding is to nearest with exact halves rounded up (10.5 gives 11; 0.5 gives 1).
- R5: Results below 0 give 0 and results above 255 give 255.
- R6: Mode code 0 uses the identity matrix (C[0]=C[5]=C[10]=0x2000, all else 0).
- R7: Mode code 2 uses the built-in standard-definition matrix, rows Y, Cb, Cr over inputs R, G, B: {2449, 4809, 934, 0}, {-1382, -2714, 4096, 4096}, {4096, -3430, -666, 4096}.
- R8: Mode code 3 uses the built-in high-definition matrix: {1742, 5859, 591, 0}, {-939, -3157, 4096, 4096}, {4096, -3720, -376, 4096}.
- R9: Mode code 4 uses bank A and mode code 5 uses bank B. Register address 0 holds the mode in bits [2:0]; addresses 1 to 6 are bank A and 7 to 12 are bank B; the k-th register of a bank (k = 0..5) holds C[2k] in bits [15:0] and C[2k+1] in bits [31:16].
- R10: Writing the registers of the bank that is not selected leaves the output of the selected matrix unchanged.
- R11: The mode only changes on a write to address 0 and takes effect for pixels accepted after that write's clock edge; a pixel accepted in the same cycle as the write uses the previous mode.
- R12: Mode codes 1, 6 and 7 behave as pass-through (identity matrix).
- R13: Reads are combinational: address 0 returns the mode in bits [2:0] and zeros above, addresses 1 to 12 return the stored word, and addresses 13 to 15 return 0; writes to 13 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input pixel qualifier |
| in_c0 | input | 12 | Input component 0 (R), 8.4 unsigned |
| in_c1 | input | 12 | Input component 1 (G), 8.4 unsigned |
| in_c2 | input | 12 | Input component 2 (B), 8.4 unsigned |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 8 | Output row 0 result |
| out_c1 | output | 8 | Output row 1 result |
| out_c2 | output | 8 | Output row 2 result |

## Verification
A pixel result is due on the third rising edge after the edge that accepts it, so the bench drives a pixel on a falling edge, confirms out_valid is still low on the next two falling edges and compares the three outputs on the third. Register writes act on the edge that follows the write cycle and reads are combinational, so read checks sample shortly after the address is set. The mode-switch case drives a control write and a pixel in the same cycle and expects that pixel under the old matrix and the pixel one cycle later under the new one, three and four edges later respectively.

// File: rtl/cmat_pkg.sv
package cmat_pkg;
   localparam int NCH       = 3;
   localparam int NCOEF     = NCH * (NCH + 1);
   localparam int PAIRS     = NCOEF / 2;
   localparam int COEF_W    = 16;
   localparam int COEF_FRAC = 13;
   localparam int MODE_W    = 3;

   localparam logic [MODE_W-1:0] MODE_THRU   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_STD_SD = 3'd2;
   localparam logic [MODE_W-1:0] MODE_STD_HD = 3'd3;
   localparam logic [MODE_W-1:0] MODE_BANK_A = 3'd4;
   localparam logic [MODE_W-1:0] MODE_BANK_B = 3'd5;

   typedef logic [NCOEF-1:0][COEF_W-1:0] coef_set_t;

   // Row-major: Y, Cb, Cr rows over R, G, B columns, offset last.
   localparam logic signed [COEF_W-1:0] SD_TBL [NCOEF] = '{
      16'sd2449,  16'sd4809,  16'sd934,  16'sd0,
      -16'sd1382, -16'sd2714, 16'sd4096, 16'sd4096,
      16'sd4096,  -16'sd3430, -16'sd666, 16'sd4096};
   localparam logic signed [COEF_W-1:0] HD_TBL [NCOEF] = '{
      16'sd1742,  16'sd5859,  16'sd591,  16'sd0,
      -16'sd939,  -16'sd3157, 16'sd4096, 16'sd4096,
      16'sd4096,  -16'sd3720, -16'sd376, 16'sd4096};

   function automatic logic [COEF_W-1:0] ident_coef(input int idx);
      return ((idx % (NCH + 2)) == 0) ? COEF_W'(1 << COEF_FRAC) : '0;
   endfunction
endpackage

// File: rtl/cmat_regs.sv
module cmat_regs
   import cmat_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic [MODE_W-1:0] mode,
   output coef_set_t         bank_a,
   output coef_set_t         bank_b
);
   localparam int NREG = 2 * PAIRS;

   logic [MODE_W-1:0]          mode_q;
   logic [NREG-1:0][31:0]      word_q;
   logic                       ctrl_hit;

   assign ctrl_hit = wr_en && (wr_addr == '0);
   assign mode     = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_THRU;
      else if (ctrl_hit) mode_q <= wr_data[MODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < NREG; k++)
            if (wr_addr == ADDR_W'(k + 1)) word_q[k] <= wr_data;
      end
   end

   always_comb begin
      for (int k = 0; k < PAIRS; k++) begin
         bank_a[2*k]   = word_q[k][COEF_W-1:0];
         bank_a[2*k+1] = word_q[k][2*COEF_W-1:COEF_W];
         bank_b[2*k]   = word_q[PAIRS+k][COEF_W-1:0];
         bank_b[2*k+1] = word_q[PAIRS+k][2*COEF_W-1:COEF_W];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) rd_data[MODE_W-1:0] = mode_q;
      else
         for (int k = 0; k < NREG; k++)
            if (rd_addr == ADDR_W'(k + 1)) rd_data = word_q[k];
   end

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_hit |=> $stable(mode_q));

   for (genvar k = 0; k < NREG; k++) begin : g_hold
      // R13
      word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_addr == ADDR_W'(k + 1))) |=> $stable(word_q[k]));
   end
endmodule

// File: rtl/cmat_select.sv
module cmat_select
   import cmat_pkg::*;
#(
   parameter bit FIXED_EN = 1'b1
) (
   input  logic [MODE_W-1:0] mode,
   input  coef_set_t         bank_a,
   input  coef_set_t         bank_b,
   output coef_set_t         coefs
);
   if (FIXED_EN) begin : g_fixed
      always_comb begin
         for (int i = 0; i < NCOEF; i++) begin
            unique case (mode)
               MODE_STD_SD: coefs[i] = SD_TBL[i];
               MODE_STD_HD: coefs[i] = HD_TBL[i];
               MODE_BANK_A: coefs[i] = bank_a[i];
               MODE_BANK_B: coefs[i] = bank_b[i];
               default:     coefs[i] = ident_coef(i);
            endcase
         end
      end
   end else begin : g_prog_only
      always_comb begin
         for (int i = 0; i < NCOEF; i++) begin
            unique case (mode)
               MODE_BANK_A: coefs[i] = bank_a[i];
               MODE_BANK_B: coefs[i] = bank_b[i];
               default:     coefs[i] = ident_coef(i);
            endcase
         end
      end
   end
endmodule

// File: rtl/cmat_row.sv
module cmat_row
   import cmat_pkg::*;
#(
   parameter int IN_W    = 12,
   parameter int IN_FRAC = 4,
   parameter int OUT_W   = 8
) (
   input  logic                         clk,
   input  logic                         en_mul,
   input  logic                         en_sum,
   input  logic                         en_out,
   input  logic [NCH-1:0][IN_W-1:0]     x,
   input  logic [NCH:0][COEF_W-1:0]     c,
   output logic [OUT_W-1:0]             y
);
   localparam int IN_INT = IN_W - IN_FRAC;
   localparam int PROD_W = COEF_W + IN_W + 1;
   localparam int ACC_W  = PROD_W + 2;
   localparam int SHR    = COEF_FRAC + IN_FRAC - (OUT_W - IN_INT);
   localparam logic signed [ACC_W-1:0] RND    = ACC_W'(64'd1 << (SHR - 1));
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'd1 << OUT_W) - 1);

   if (SHR < 1) begin : g_bad_scale
      $error("cmat_row: OUT_W too wide for the input format");
   end

   logic signed [PROD_W-1:0] prod_q [NCH];
   logic signed [ACC_W-1:0]  ofs_q;
   logic signed [ACC_W-1:0]  sum_d, sum_q, scaled;
   logic [OUT_W-1:0]         y_q;

   always_ff @(posedge clk) begin
      if (en_mul) begin
         for (int j = 0; j < NCH; j++)
            prod_q[j] <= PROD_W'($signed({1'b0, x[j]})) * PROD_W'($signed(c[j]));
         ofs_q <= ACC_W'($signed(c[NCH])) <<< IN_W;
      end
   end

   always_comb begin
      sum_d = ofs_q + RND;
      for (int j = 0; j < NCH; j++) sum_d = sum_d + ACC_W'(prod_q[j]);
   end

   always_ff @(posedge clk) begin
      if (en_sum) sum_q <= sum_d;
   end

   assign scaled = sum_q >>> SHR;

   always_ff @(posedge clk) begin
      if (en_out) begin
         if (scaled < 0)           y_q <= '0;
         else if (scaled > SAT_HI) y_q <= '1;
         else                      y_q <= scaled[OUT_W-1:0];
      end
   end

   assign y = y_q;
endmodule

// File: rtl/cmat_convert.sv
module cmat_convert
   import cmat_pkg::*;
#(
   parameter int IN_W     = 12,
   parameter int IN_FRAC  = 4,
   parameter int OUT_W    = 8,
   parameter int ADDR_W   = 4,
   parameter bit FIXED_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_c0,
   input  logic [IN_W-1:0]   in_c1,
   input  logic [IN_W-1:0]   in_c2,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_c0,
   output logic [OUT_W-1:0]  out_c1,
   output logic [OUT_W-1:0]  out_c2
);
   localparam int LAT = 3;

   if (IN_FRAC < 0 || IN_FRAC >= IN_W) begin : g_bad_frac
      $error("cmat_convert: IN_FRAC must lie inside IN_W");
   end
   if ((1 << ADDR_W) < 2 * PAIRS + 1) begin : g_bad_addr
      $error("cmat_convert: ADDR_W cannot reach every register");
   end

   logic [MODE_W-1:0]          mode;
   coef_set_t                  bank_a, bank_b, coefs;
   logic [NCH-1:0][IN_W-1:0]   pix_x;
   logic [LAT-1:0]             v_q;

   assign pix_x = {in_c2, in_c1, in_c0};

   cmat_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mode(mode), .bank_a(bank_a), .bank_b(bank_b));

   cmat_select #(.FIXED_EN(FIXED_EN)) u_sel (
      .mode(mode), .bank_a(bank_a), .bank_b(bank_b), .coefs(coefs));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[LAT-2:0], in_valid};
   end

   for (genvar r = 0; r < NCH; r++) begin : g_row
      logic [OUT_W-1:0] y;
      cmat_row #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W)) u_row (
         .clk(clk), .en_mul(in_valid), .en_sum(v_q[0]), .en_out(v_q[1]),
         .x(pix_x), .c(coefs[(NCH+1)*r +: NCH+1]), .y(y));
   end

   assign out_valid = v_q[LAT-1];
   assign out_c0    = g_row[0].y;
   assign out_c1    = g_row[1].y;
   assign out_c2    = g_row[2].y;

   // R2
   lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid);

   // R2
   lat_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));
endmodule

// File: tb/cmat_convert_tb.sv
module cmat_convert_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        in_valid = 1'b0;
   logic [11:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
   logic        out_valid;
   logic [7:0]  out_c0, out_c1, out_c2;

   always #5 clk = ~clk;

   cmat_convert u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
      .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int bank [2][12];

   localparam int SD[12] = '{2449, 4809, 934, 0, -1382, -2714, 4096, 4096,
                             4096, -3430, -666, 4096};
   localparam int HD[12] = '{1742, 5859, 591, 0, -939, -3157, 4096, 4096,
                             4096, -3720, -376, 4096};

   // {mode[3:0], x0, x1, x2}
   localparam int NVEC = 12;
   localparam logic [39:0] VEC [NVEC] = '{
      {4'd0, 12'h000, 12'h7F0, 12'hFF0},
      {4'd0, 12'h018, 12'h017, 12'hFF8},
      {4'd2, 12'hFF0, 12'hFF0, 12'hFF0},
      {4'd2, 12'hFF0, 12'h000, 12'h000},
      {4'd3, 12'h100, 12'h800, 12'h400},
      {4'd3, 12'h000, 12'h000, 12'h000},
      {4'd4, 12'h900, 12'h123, 12'h210},
      {4'd4, 12'h400, 12'h000, 12'h000},
      {4'd5, 12'h111, 12'h222, 12'h333},
      {4'd1, 12'h0A8, 12'h0B8, 12'h0C8},
      {4'd6, 12'h3C4, 12'h055, 12'hABC},
      {4'd7, 12'h008, 12'h007, 12'h009}};
   localparam string TAGS[NVEC] = '{"R6", "R4 R5 R6", "R7 R3", "R7", "R8", "R8",
                                    "R9 R4 R5", "R9 R5", "R9", "R12 R4", "R12", "R12"};

   function automatic int coef_of(int mode, int i);
      case (mode)
         2:       return SD[i];
         3:       return HD[i];
         4:       return bank[0][i];
         5:       return bank[1][i];
         default: return (i == 0 || i == 5 || i == 10) ? 8192 : 0;
      endcase
   endfunction

   // R3 R4 R5 reference
   function automatic int ref_ch(int mode, int r, int x0, int x1, int x2);
      longint acc = longint'(coef_of(mode, 4*r)) * x0 + longint'(coef_of(mode, 4*r+1)) * x1
                  + longint'(coef_of(mode, 4*r+2)) * x2 + longint'(coef_of(mode, 4*r+3)) * 4096;
      longint q = (acc + 65536) >>> 17;
      if (q < 0) return 0;
      if (q > 255) return 255;
      return int'(q);
   endfunction

   task automatic reg_write(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_bank(int b);
      for (int k = 0; k < 6; k++)
         reg_write(1 + 6*b + k, {16'(bank[b][2*k+1]), 16'(bank[b][2*k])});
   endtask

   task automatic rd_check(string tag, int a, logic [31:0] exp);
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic cmp_out(string tag, int mode, int x0, int x1, int x2, bit early);
      int e0 = ref_ch(mode, 0, x0, x1, x2);
      int e1 = ref_ch(mode, 1, x0, x1, x2);
      int e2 = ref_ch(mode, 2, x0, x1, x2);
      checks++;
      if (early || out_valid !== 1'b1 || out_c0 != 8'(e0) || out_c1 != 8'(e1) || out_c2 != 8'(e2)) begin
         fails++;
         $display("FAIL %s: valid=%0b early=%0b got %0d %0d %0d expected 1/0 %0d %0d %0d",
                  tag, out_valid, early, out_c0, out_c1, out_c2, e0, e1, e2);
      end
   endtask

   // One pixel: result due on the third rising edge after acceptance.
   task automatic run_pix(string tag, int mode, int x0, int x1, int x2);
      bit early;
      @(negedge clk);
      in_valid = 1'b1; in_c0 = 12'(x0); in_c1 = 12'(x1); in_c2 = 12'(x2);
      @(negedge clk);
      in_valid = 1'b0; early = out_valid;
      @(negedge clk);
      early = early | out_valid;
      @(negedge clk);
      cmp_out(tag, mode, x0, x1, x2, early);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      bank[0] = '{16384, 0, 0, 0, -8192, 0, 0, 4096, 0, 0, 4096, -512};
      bank[1] = '{0, 8192, 0, 0, 0, 0, 8192, 0, 8192, 0, 0, 0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: out_valid got %b expected 0", out_valid);
      end
      rd_check("R1 mode", 0, 32'h0);
      rd_check("R1 bank A first", 1, 32'h0);
      rd_check("R1 bank B last", 12, 32'h0);
      run_pix("R1 R6 default pass-through", 0, 12'h155, 12'h2AA, 12'h080);

      load_bank(0);
      load_bank(1);

      // Table of modes and inputs, expected values from the reference
      for (int i = 0; i < NVEC; i++) begin
         reg_write(0, {28'd0, VEC[i][39:36]});
         run_pix($sformatf("%s vec %0d", TAGS[i], i), int'(VEC[i][39:36]),
                 int'(VEC[i][35:24]), int'(VEC[i][23:12]), int'(VEC[i][11:0]));
      end

      // R2: three pixels back to back
      reg_write(0, 32'd0);
      begin
         bit bad = 1'b0;
         @(negedge clk); in_valid = 1'b1; in_c0 = 12'h010; in_c1 = 12'h020; in_c2 = 12'h030;
         @(negedge clk); bad |= out_valid; in_c0 = 12'h040; in_c1 = 12'h050; in_c2 = 12'h060;
         @(negedge clk); bad |= out_valid; in_c0 = 12'h070; in_c1 = 12'h080; in_c2 = 12'h090;
         @(negedge clk); in_valid = 1'b0;
         cmp_out("R2 stream first", 0, 12'h010, 12'h020, 12'h030, bad);
         @(negedge clk); cmp_out("R2 stream second", 0, 12'h040, 12'h050, 12'h060, 1'b0);
         @(negedge clk); cmp_out("R2 stream third", 0, 12'h070, 12'h080, 12'h090, 1'b0);
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: out_valid after stream got %b expected 0", out_valid);
         end
      end

      // R10: rewrite bank B while bank A is selected
      reg_write(0, 32'd4);
      bank[1] = '{4096, 4096, 0, 0, 0, 0, -4096, 4096, 0, 0, 0, 8191};
      load_bank(1);
      run_pix("R10 bank A unaffected", 4, 12'h300, 12'h123, 12'h456);
      reg_write(0, 32'd5);
      run_pix("R10 R9 new bank B", 5, 12'h300, 12'h640, 12'h456);

      // R11: control write and pixel in the same cycle
      begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'd0;
         in_valid = 1'b1; in_c0 = 12'h200; in_c1 = 12'h300; in_c2 = 12'h400;
         @(negedge clk);
         wr_en = 1'b0;
         in_c0 = 12'h210; in_c1 = 12'h310; in_c2 = 12'h410;
         @(negedge clk); in_valid = 1'b0;
         @(negedge clk); cmp_out("R11 same-cycle pixel keeps old mode", 5, 12'h200, 12'h300, 12'h400, 1'b0);
         @(negedge clk); cmp_out("R11 next pixel uses new mode", 0, 12'h210, 12'h310, 12'h410, 1'b0);
      end

      // R13: readback and ignored addresses
      reg_write(3, 32'h1234_ABCD);
      rd_check("R13 word readback", 3, 32'h1234_ABCD);
      reg_write(0, 32'hFFFF_FFFC);
      rd_check("R13 mode readback", 0, 32'h0000_0004);
      reg_write(13, 32'hDEAD_BEEF);
      reg_write(15, 32'hCAFE_F00D);
      rd_check("R13 unmapped read", 13, 32'h0);
      rd_check("R13 unmapped write ignored", 15, 32'h0);
      rd_check("R13 bank A intact", 1, {16'(bank[0][1]), 16'(bank[0][0])});
      rd_check("R13 bank B intact", 12, {16'(bank[1][11]), 16'(bank[1][10])});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule